// File: doc/BRIEF.md
# Converter Serial Configuration Port

This block is the device-side serial port of a multiplexed 12-bit analog-to-digital converter. A host talks to it over a four-wire, full-duplex link made of an active-low select, a shift clock, a data input and a data output. In each select frame the host clocks in an 8-bit configuration word. At the same time the port clocks out the result of the conversion that the previous frame asked for. When select is released after a complete word, the port latches the new configuration. It presents the decoded channel and polarity to the converter and pulses a start strobe. The converter later returns a 12-bit code together with a one-cycle done strobe.

The serial inputs are sampled in the system clock domain and their edges are detected there. The output word is pipelined by one frame: its bit order and length come from the configuration word that requested the conversion, not from the word arriving in the current frame. The input code is straight binary. In bipolar mode the port converts it to two's complement (MSB inverted) as it stores it. Frames that end early, and frames that complete while a conversion is still running, leave the configuration and the converter unchanged.

Top module: `adc_link_top`

## Requirements
- R1: After reset, doutEn, dout and convStart are 0, convChannel is 0 and convBipolar is 0. The first frame shifts out all zeros.
- R2: doutEn is 1 only while the sampled chip select is low. dout is 0 whenever doutEn is 0.
- R3: The configuration word is taken from din on the first 8 rising sclk edges of a frame. The first bit received is bit 7. Fields: bit 7 single/differential, bit 6 odd/sign, bits 5:4 mux select, bit 3 unipolar (1) or bipolar (0), bit 2 MSB-first (1) or LSB-first (0), bits 1:0 word length. din on later rising edges of the same frame has no effect.
- R4: When chip select rises after a complete word and no conversion is running, convStart pulses high for exactly one clock. At the same time convChannel becomes word bits 7:4 and convBipolar becomes the inverse of bit 3.
- R5: The bits shifted out in a frame are the result of the conversion requested by the last accepted word. They use that word's bit order and length.
- R6: With MSB-first set, the kept result bits go out from the most significant down. With it clear, they go out from the lowest kept bit up.
- R7: Word length 00 gives 8 bits, made of the top 8 result bits. Lengths 01 and 10 give 12 bits. Length 11 gives 16 bits: the 12 result bits followed by zeros. Every bit after the word length is 0.
- R8: In unipolar mode the stored result equals convResult. In bipolar mode it equals convResult XOR 0x800.
- R9: If chip select rises before 8 bits have been received, there is no convStart and the channel, polarity, output format and stored result are all unchanged.
- R10: convChannel and convBipolar stay stable from convStart until convDone. A word that completes while a conversion is running is discarded: no convStart, no change.
- R11: dout changes only after a falling sclk edge. It is stable across rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial shift clock from the host, idle low |
| din | input | 1 | Serial configuration data from the host |
| dout | output | 1 | Serial result data to the host |
| doutEn | output | 1 | Output enable for dout; low means tri-stated |
| convStart | output | 1 | One-cycle conversion start pulse |
| convChannel | output | 4 | Mux code {single/diff, odd/sign, sel1, sel0} |
| convBipolar | output | 1 | Polarity of the pending conversion |
| convResult | input | 12 | Straight-binary code from the converter |
| convDone | input | 1 | One-cycle strobe: convResult is valid |

## Verification
The hardest state to reach is a second complete frame that finishes while the converter is still busy with the first. The frame must close before the done strobe, yet the rejected word must later prove to have had no effect. The bench's converter model has a delay that can be set at run time. It is stretched well beyond a frame length, so two full frames fit inside one conversion. The next frame after completion must then carry the first word's format and data. Aborted frames are covered by releasing select after five bits and confirming that the following full frame repeats the earlier output unchanged.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  localparam int RES_BITS     = 12;
  localparam int CFG_BITS     = 8;
  localparam int MAX_OUT_BITS = 16;
  localparam int CHAN_BITS    = 4;

  typedef struct packed {
    logic frameStart;
    logic shiftIn;
    logic advance;
    logic commit;
    logic capture;
  } linkStrobe_t;

endpackage

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
  import adc_link_pkg::*;
#(
  parameter int CFG_W = CFG_BITS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        din,
  input  logic        convDone,
  output linkStrobe_t strobe,
  output logic        dinSync,
  output logic        doutEn,
  output logic        busy,
  output logic        convStart
);

  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CFG_W);

  logic csQ, csQ2, sclkQ, sclkQ2;
  logic [CNT_W-1:0] bitCnt;
  logic csFall, csRise, sclkRise, sclkFall, active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ     <= 1'b1;
      csQ2    <= 1'b1;
      sclkQ   <= 1'b0;
      sclkQ2  <= 1'b0;
      dinSync <= 1'b0;
    end else begin
      csQ     <= csN;
      csQ2    <= csQ;
      sclkQ   <= sclk;
      sclkQ2  <= sclkQ;
      dinSync <= din;
    end
  end

  always_comb begin
    csFall   = csQ2 & ~csQ;
    csRise   = ~csQ2 & csQ;
    active   = ~csQ2;
    sclkRise = sclkQ & ~sclkQ2;
    sclkFall = ~sclkQ & sclkQ2;
  end

  always_comb begin
    strobe.frameStart = csFall;
    strobe.shiftIn    = active & sclkRise & (bitCnt < FULL_CNT);
    strobe.advance    = active & sclkFall;
    strobe.commit     = csRise & (bitCnt == FULL_CNT) & ~busy;
    strobe.capture    = convDone & busy;
    doutEn            = active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      busy      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      if (strobe.frameStart) begin
        bitCnt <= '0;
      end else if (strobe.shiftIn) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.commit) begin
        busy <= 1'b1;
      end else if (strobe.capture) begin
        busy <= 1'b0;
      end
      convStart <= strobe.commit;
    end
  end

  // R4: the start strobe lasts one cycle
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R9: a start only follows a frame that delivered a full word
  a_r9_start_full_word: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> ($past(bitCnt) == FULL_CNT));

  // R10: no start while the previous conversion was running
  a_r10_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !$past(busy));

endmodule

// File: rtl/adc_link_dpath.sv
module adc_link_dpath
  import adc_link_pkg::*;
#(
  parameter int RES_W     = RES_BITS,
  parameter int CFG_W     = CFG_BITS,
  parameter int OUT_W     = MAX_OUT_BITS,
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  linkStrobe_t          strobe,
  input  logic                 dinSync,
  input  logic                 doutEn,
  input  logic [RES_W-1:0]     convResult,
  output logic                 dout,
  output logic [CHAN_BITS-1:0] convChannel,
  output logic                 convBipolar
);

  localparam int LEN_W      = $clog2(OUT_W + 1);
  localparam int RIDX_W     = $clog2(RES_W);
  localparam int KEEP_SHORT = (SHORT_LEN < RES_W) ? SHORT_LEN : RES_W;
  localparam int KEEP_LONG  = (LONG_LEN < RES_W) ? LONG_LEN : RES_W;
  localparam int UNI_POS    = CFG_W - CHAN_BITS - 1;
  localparam int ORDER_POS  = UNI_POS - 1;

  logic [CFG_W-1:0]     cfgShift;
  logic [CHAN_BITS-1:0] chanReg;
  logic                 bipReg;
  logic                 fmtMsbf;
  logic [1:0]           fmtWl;
  logic [RES_W-1:0]     resultReg;
  logic [OUT_W-1:0]     outShift;
  logic [OUT_W-1:0]     sendVec;
  logic [LEN_W-1:0]     keptLen;

  always_comb begin
    case (fmtWl)
      2'b00:   keptLen = LEN_W'(KEEP_SHORT);
      2'b11:   keptLen = LEN_W'(KEEP_LONG);
      default: keptLen = LEN_W'(RES_W);
    endcase
  end

  for (genvar k = 0; k < OUT_W; k++) begin : gSend
    if (k < RES_W) begin : gData
      logic [RIDX_W-1:0] lsbPick;
      assign lsbPick = RIDX_W'(RES_W + k - int'(keptLen));
      assign sendVec[OUT_W-1-k] = (LEN_W'(k) < keptLen) ?
        (fmtMsbf ? resultReg[RES_W-1-k] : resultReg[lsbPick]) : 1'b0;
    end else begin : gPad
      assign sendVec[OUT_W-1-k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgShift  <= '0;
      chanReg   <= '0;
      bipReg    <= 1'b0;
      fmtMsbf   <= 1'b0;
      fmtWl     <= 2'b00;
      resultReg <= '0;
      outShift  <= '0;
    end else begin
      if (strobe.shiftIn) begin
        cfgShift <= {cfgShift[CFG_W-2:0], dinSync};
      end
      if (strobe.commit) begin
        chanReg <= cfgShift[CFG_W-1 -: CHAN_BITS];
        bipReg  <= ~cfgShift[UNI_POS];
        fmtMsbf <= cfgShift[ORDER_POS];
        fmtWl   <= cfgShift[1:0];
      end
      if (strobe.capture) begin
        resultReg <= convResult ^ {bipReg, {(RES_W-1){1'b0}}};
      end
      if (strobe.frameStart) begin
        outShift <= sendVec;
      end else if (strobe.advance) begin
        outShift <= {outShift[OUT_W-2:0], 1'b0};
      end
    end
  end

  assign dout        = doutEn & outShift[OUT_W-1];
  assign convChannel = chanReg;
  assign convBipolar = bipReg;

  // R9: configuration only moves on an accepted word
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable({chanReg, bipReg, fmtMsbf, fmtWl}));

  // R11: the output register only moves at frame start or a falling edge
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.frameStart && !strobe.advance) |=> $stable(outShift));

endmodule

// File: rtl/adc_link_top.sv
module adc_link_top
  import adc_link_pkg::*;
#(
  parameter int RES_W     = RES_BITS,
  parameter int CFG_W     = CFG_BITS,
  parameter int OUT_W     = MAX_OUT_BITS,
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 din,
  output logic                 dout,
  output logic                 doutEn,
  output logic                 convStart,
  output logic [CHAN_BITS-1:0] convChannel,
  output logic                 convBipolar,
  input  logic [RES_W-1:0]     convResult,
  input  logic                 convDone
);

  linkStrobe_t strobe;
  logic        dinSync;
  logic        busy;

  adc_link_ctrl #(
    .CFG_W(CFG_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .din      (din),
    .convDone (convDone),
    .strobe   (strobe),
    .dinSync  (dinSync),
    .doutEn   (doutEn),
    .busy     (busy),
    .convStart(convStart)
  );

  adc_link_dpath #(
    .RES_W    (RES_W),
    .CFG_W    (CFG_W),
    .OUT_W    (OUT_W),
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dinSync    (dinSync),
    .doutEn     (doutEn),
    .convResult (convResult),
    .dout       (dout),
    .convChannel(convChannel),
    .convBipolar(convBipolar)
  );

  // R2: no data on the line while deselected
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !doutEn |-> !dout);

  // R10: mux code and polarity hold during a conversion
  a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convStart) |-> $stable({convChannel, convBipolar}));

endmodule

// File: tb/test_adc_link_top.sv
module test_adc_link_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] convResult = '0;
  logic        convDone = 1'b0;
  logic        dout, doutEn, convStart, convBipolar;
  logic [3:0]  convChannel;

  int testCount = 0;
  int failCount = 0;
  int startCount = 0;
  int stubCnt = 0;
  int stubDelay = 20;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_link_top i_adc_link_top (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .dout(dout), .doutEn(doutEn), .convStart(convStart),
    .convChannel(convChannel), .convBipolar(convBipolar),
    .convResult(convResult), .convDone(convDone)
  );

  function automatic logic [11:0] codeOf(input logic [3:0] ch);
    return {ch, 8'h00} + 12'(ch) * 12'd37 + 12'h0C9;
  endfunction

  function automatic logic [11:0] dataOf(input logic [7:0] c);
    return codeOf(c[7:4]) ^ (c[3] ? 12'h000 : 12'h800);
  endfunction

  function automatic logic [15:0] expVec(input logic [7:0] c, input logic [11:0] d);
    int len, kept;
    logic [15:0] v;
    v = '0;
    case (c[1:0])
      2'b00:   len = 8;
      2'b11:   len = 16;
      default: len = 12;
    endcase
    kept = (len < 12) ? len : 12;
    for (int k = 0; k < 16; k++) begin
      if (k < kept) v[15-k] = c[2] ? d[11-k] : d[12-kept+k];
    end
    return v;
  endfunction

  // converter model
  always @(posedge clk) begin
    if (!rstN) begin
      stubCnt  <= 0;
      convDone <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (convStart) begin
        stubCnt    <= stubDelay;
        startCount <= startCount + 1;
      end else if (stubCnt == 1) begin
        stubCnt    <= 0;
        convDone   <= 1'b1;
        convResult <= codeOf(convChannel);
      end else if (stubCnt > 1) begin
        stubCnt <= stubCnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (stubCnt != 0 || convDone) @(negedge clk);
    settle();
  endtask

  task automatic runFrame(input logic [7:0] cfg, input int nRise, output logic [15:0] got);
    logic pre;
    got = '0;
    csN = 1'b0;
    settle();
    for (int k = 0; k < nRise; k++) begin
      chk(doutEn == 1'b1, "R2 enable in frame", doutEn, 1);
      pre = dout;
      got[15-k] = dout;
      din = (k < 8) ? cfg[7-k] : ~cfg[k-8];
      sclk = 1'b1;
      settle();
      chk(dout == pre, "R11 stable across rise", dout, pre);
      sclk = 1'b0;
      settle();
    end
    csN = 1'b1;
    settle();
    chk(doutEn == 1'b0 && dout == 1'b0, "R2 idle line", {doutEn, dout}, 0);
  endtask

  initial begin
    logic [7:0]  prevCfg;
    logic [11:0] prevData;
    logic [15:0] got;
    logic [15:0] exp;
    int s0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle();
    chk(doutEn == 0 && dout == 0, "R1 line after reset", {doutEn, dout}, 0);
    chk(convStart == 0, "R1 start after reset", convStart, 0);
    chk(convChannel == 0 && convBipolar == 0, "R1 mux after reset", {convChannel, convBipolar}, 0);
    prevCfg  = 8'h00;
    prevData = 12'h000;

    // sweep every configuration word
    for (int c = 0; c < 256; c++) begin
      s0 = startCount;
      runFrame(8'(c), 16, got);
      exp = expVec(prevCfg, prevData);
      chk(got == exp, "R5/R6/R7/R8 output word", got, exp);
      chk(startCount == s0 + 1, "R4 one start pulse", startCount - s0, 1);
      chk(convChannel == 4'(c >> 4), "R3/R4 channel", convChannel, c >> 4);
      chk(convBipolar == !c[3], "R4 polarity", convBipolar, !c[3]);
      waitIdle();
      prevCfg  = 8'(c);
      prevData = dataOf(8'(c));
    end

    // R9: aborted frame
    s0 = startCount;
    runFrame(8'h25, 5, got);
    exp = expVec(prevCfg, prevData);
    chk(startCount == s0, "R9 no start on abort", startCount - s0, 0);
    chk(convChannel == prevCfg[7:4], "R9 channel kept", convChannel, prevCfg[7:4]);
    chk(got[15:11] == exp[15:11], "R9 partial output", got[15:11], exp[15:11]);
    runFrame(8'h94, 16, got);
    chk(got == exp, "R9 format and result kept", got, exp);
    waitIdle();
    prevCfg  = 8'h94;
    prevData = dataOf(8'h94);

    // R10: frame completing during a long conversion
    stubDelay = 3000;
    s0 = startCount;
    runFrame(8'hB2, 16, got);
    exp = expVec(prevCfg, prevData);
    chk(got == exp, "R5 output before busy", got, exp);
    chk(startCount == s0 + 1, "R10 first start", startCount - s0, 1);
    runFrame(8'h4F, 16, got);
    chk(startCount == s0 + 1, "R10 no start while busy", startCount - s0, 1);
    chk(convChannel == 4'hB && convBipolar == 1'b1, "R10 mux held",
        {convChannel, convBipolar}, {4'hB, 1'b1});
    waitIdle();
    stubDelay = 20;
    runFrame(8'h61, 16, got);
    exp = expVec(8'hB2, dataOf(8'hB2));
    chk(got == exp, "R10 busy word discarded", got, exp);
    chk(startCount == s0 + 2, "R10 start after idle", startCount - s0, 2);
    waitIdle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule